// File: doc/BRIEF.md
# DMA Channel Address and Count Register Bank

This block holds the programmable address and count registers for four DMA channels. Software reaches it through a narrow port interface. Each channel keeps two base registers, an address and a count. From these it derives two live values: a current address, and a progress count that an external transfer engine updates. When software finishes writing a base register, the channel's live state reloads.

A single byte pointer is shared by all channels. It decides whether an 8-bit access touches the low byte or the high byte of a 16-bit register, and every 8-bit access, read or write, advances it. A clear input forces the pointer back to the low byte. A 16-bit write path loads a whole base register in one access and leaves the pointer alone.

A read returns one byte at a time. For the address register it returns the live address plus progress. For the count register it returns the base count minus progress. One parameter chooses between a byte controller and a word controller. The word controller scales addresses and counts by two and decodes its registers on even port addresses only.

Top module: `dma_chan_regs`

## Requirements
- R1: With `SHIFT`=0 the channel index is `port_addr[2:1]` and the register select is `port_addr[0]` (0 = address, 1 = count). With `SHIFT`=1 the channel index is `port_addr[3:2]` and the select is `port_addr[1]`. An access with `port_addr[0]`=1 on the word controller is ignored: no register, pointer or `rdata` change.
- R2: An 8-bit write (`wr8`) taken while the pointer is 0 replaces bits [7:0] of the selected base register with `wdata[7:0]`. Bits [15:8] and the channel's live state are unchanged.
- R3: An 8-bit write taken while the pointer is 1 replaces bits [15:8] of the selected base register with `wdata[7:0]` and then reinitialises that channel.
- R4: Every decoded 8-bit read or write is served using the pointer value from before the access, and the pointer toggles after it.
- R5: A 16-bit write (`wr16`) replaces the whole selected base register with `wdata` and reinitialises the channel in the same cycle. The pointer is neither used nor changed.
- R6: Reinitialising a channel loads its current address with the base address shifted left by `SHIFT` and clears its progress count to 0.
- R7: An 8-bit read of an address register returns bits [SHIFT+8·p+7 : SHIFT+8·p] of (current address + progress), taken modulo 2^18, where p is the pointer. `rdata` is registered, valid one cycle after the read, and held otherwise.
- R8: An 8-bit read of a count register returns the same byte slice of ((base count << `SHIFT`) − progress), taken modulo 2^18.
- R9: `ff_clear` forces the pointer to 0 at the next edge. It wins over a toggle from an 8-bit access in the same cycle, and that access itself still uses the old pointer.
- R10: When `prog_valid` is high, the progress count of channel `prog_ch` is loaded with `prog_count`. If the same channel is reinitialised in that cycle, the reinitialisation wins.
- R11: After synchronous reset, all base, current and progress values, the pointer and `rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_addr | input | SHIFT+3 | Port offset within the bank |
| wr8 | input | 1 | 8-bit write strobe |
| wr16 | input | 1 | 16-bit write strobe |
| rd8 | input | 1 | 8-bit read strobe |
| wdata | input | 16 | Write data (8-bit writes use [7:0]) |
| ff_clear | input | 1 | Force byte pointer to low byte |
| prog_valid | input | 1 | Progress update strobe |
| prog_ch | input | 2 | Channel index for progress update |
| prog_count | input | 18 | New progress count |
| rdata | output | 8 | Registered read byte |

## Verification
On every cycle, the assertions check how the pointer moves: clearing wins, a decoded 8-bit access toggles it, and anything else leaves it alone. They also check that a reinitialisation clears progress, that a low-byte write keeps the high byte, that progress loads on its strobe, and that `rdata` holds between reads. The arithmetic of read-back can only be shown by the bench's scenarios. That covers the sum and difference against progress, the byte slice chosen by shift and pointer, and aliasing between the two decodes. The same holds for the reload of the live address after a high-byte or 16-bit write, and for the ignored odd ports of the word controller.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int VAL_W = 18;
  localparam int REG_W = 16;
  typedef enum logic { SEL_ADDR = 1'b0, SEL_CNT = 1'b1 } reg_sel_e;
endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  output logic ptr
);
  always_ff @(posedge clk) begin
    if (rst)        ptr <= 1'b0;
    else if (clear) ptr <= 1'b0;
    else if (step)  ptr <= ~ptr;
  end

  // R9: clearing wins over any toggle
  p_clear_wins_r9: assert property (@(posedge clk) disable iff (rst)
    clear |=> (ptr == 1'b0));
  // R4: an 8-bit access toggles the pointer
  p_toggle_r4: assert property (@(posedge clk) disable iff (rst)
    (step && !clear) |=> (ptr != $past(ptr)));
  // R5: no access, no movement
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!step && !clear) |=> $stable(ptr));
endmodule

// File: rtl/dma_chan_slot.sv
module dma_chan_slot
  import dma_regs_pkg::*;
#(
  parameter int SHIFT = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic             wr_full,
  input  reg_sel_e         sel,
  input  logic [REG_W-1:0] wdata,
  input  logic             prog_we,
  input  logic [VAL_W-1:0] prog_val,
  output logic [REG_W-1:0] base_addr,
  output logic [REG_W-1:0] base_cnt,
  output logic [VAL_W-1:0] cur_addr,
  output logic [VAL_W-1:0] prog
);
  logic             reinit;
  logic [REG_W-1:0] next_addr;
  logic [REG_W-1:0] next_cnt;

  assign reinit = wr_hi | wr_full;

  always_comb begin
    next_addr = base_addr;
    next_cnt  = base_cnt;
    if (sel == SEL_ADDR) begin
      if (wr_lo)   next_addr = {base_addr[15:8], wdata[7:0]};
      if (wr_hi)   next_addr = {wdata[7:0], base_addr[7:0]};
      if (wr_full) next_addr = wdata;
    end else begin
      if (wr_lo)   next_cnt = {base_cnt[15:8], wdata[7:0]};
      if (wr_hi)   next_cnt = {wdata[7:0], base_cnt[7:0]};
      if (wr_full) next_cnt = wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      prog      <= '0;
    end else begin
      base_addr <= next_addr;
      base_cnt  <= next_cnt;
      if (reinit) begin
        cur_addr <= VAL_W'(next_addr) << SHIFT;
        prog     <= '0;
      end else if (prog_we) begin
        prog <= prog_val;
      end
    end
  end

  // R6: reinitialisation clears progress
  p_reinit_clears_r6: assert property (@(posedge clk) disable iff (rst)
    reinit |=> (prog == '0));
  // R2: low-byte write keeps the high byte
  p_lo_keeps_hi_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && !wr_full && sel == SEL_ADDR) |=> (base_addr[15:8] == $past(base_addr[15:8])));
  // R10: progress loads when not reinitialised
  p_prog_load_r10: assert property (@(posedge clk) disable iff (rst)
    (prog_we && !reinit) |=> (prog == $past(prog_val)));
endmodule

// File: rtl/dma_rd_pick.sv
module dma_rd_pick
  import dma_regs_pkg::*;
#(
  parameter int SHIFT = 0
) (
  input  reg_sel_e         sel,
  input  logic             ptr,
  input  logic [VAL_W-1:0] cur_addr,
  input  logic [REG_W-1:0] base_cnt,
  input  logic [VAL_W-1:0] prog,
  output logic [7:0]       rbyte
);
  logic [VAL_W-1:0] val;
  logic [VAL_W-1:0] scaled;

  always_comb begin
    if (sel == SEL_CNT) val = (VAL_W'(base_cnt) << SHIFT) - prog;
    else                val = cur_addr + prog;
    scaled = val >> SHIFT;
    rbyte  = ptr ? scaled[15:8] : scaled[7:0];
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int SHIFT  = 0,
  parameter int NUM_CH = 4,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int ADDR_W = SHIFT + CH_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] port_addr,
  input  logic              wr8,
  input  logic              wr16,
  input  logic              rd8,
  input  logic [REG_W-1:0]  wdata,
  input  logic              ff_clear,
  input  logic              prog_valid,
  input  logic [CH_W-1:0]   prog_ch,
  input  logic [VAL_W-1:0]  prog_count,
  output logic [7:0]        rdata
);
  logic            hit;
  logic [CH_W-1:0] ch;
  reg_sel_e        sel;
  logic            ptr;
  logic            step;
  logic [7:0]      rbyte;

  logic [REG_W-1:0] base_addr [NUM_CH];
  logic [REG_W-1:0] base_cnt  [NUM_CH];
  logic [VAL_W-1:0] cur_addr  [NUM_CH];
  logic [VAL_W-1:0] prog      [NUM_CH];

  generate
    if (SHIFT != 0) begin : g_word
      assign hit = ~port_addr[0];
    end else begin : g_byte
      assign hit = 1'b1;
    end
  endgenerate

  assign ch   = port_addr[SHIFT+CH_W : SHIFT+1];
  assign sel  = reg_sel_e'(port_addr[SHIFT]);
  assign step = (wr8 | rd8) & hit;

  dma_byte_ptr u_ptr (
    .clk  (clk),
    .rst  (rst),
    .clear(ff_clear),
    .step (step),
    .ptr  (ptr)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic me;
    assign me = hit && (ch == CH_W'(i));
    dma_chan_slot #(.SHIFT(SHIFT)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .wr_lo    (me && wr8 && !ptr),
      .wr_hi    (me && wr8 && ptr),
      .wr_full  (me && wr16),
      .sel      (sel),
      .wdata    (wdata),
      .prog_we  (prog_valid && (prog_ch == CH_W'(i))),
      .prog_val (prog_count),
      .base_addr(base_addr[i]),
      .base_cnt (base_cnt[i]),
      .cur_addr (cur_addr[i]),
      .prog     (prog[i])
    );
  end

  dma_rd_pick #(.SHIFT(SHIFT)) u_pick (
    .sel     (sel),
    .ptr     (ptr),
    .cur_addr(cur_addr[ch]),
    .base_cnt(base_cnt[ch]),
    .prog    (prog[ch]),
    .rbyte   (rbyte)
  );

  always_ff @(posedge clk) begin
    if (rst)              rdata <= '0;
    else if (rd8 && hit)  rdata <= rbyte;
  end

  // R7: read data holds between reads
  p_rdata_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !rd8 |=> $stable(rdata));
  // R5: a lone 16-bit write leaves the pointer alone
  p_wr16_ptr_r5: assert property (@(posedge clk) disable iff (rst)
    (wr16 && !wr8 && !rd8 && !ff_clear) |=> $stable(ptr));
endmodule

// File: tb/dma_chan_regs_bench.sv
module dma_chan_regs_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  addr;
  logic        wr8, wr16, rd8, clr, pv;
  logic [15:0] wdata;
  logic [1:0]  pch;
  logic [17:0] pcnt;
  logic [7:0]  rdata_b, rdata_w;

  int errors = 0;
  int checks = 0;

  logic [15:0] m_base [2][4][2];
  logic [17:0] m_cur  [2][4];
  logic [17:0] m_prog [2][4];
  logic        m_ff   [2];
  logic [7:0]  m_exp  [2];

  always #(CLK_P/2) clk = ~clk;

  dma_chan_regs #(.SHIFT(0)) u_dma_chan_regs (
    .clk(clk), .rst(rst), .port_addr(addr[2:0]), .wr8(wr8), .wr16(wr16),
    .rd8(rd8), .wdata(wdata), .ff_clear(clr), .prog_valid(pv),
    .prog_ch(pch), .prog_count(pcnt), .rdata(rdata_b));

  dma_chan_regs #(.SHIFT(1)) u_dma_chan_regs_w (
    .clk(clk), .rst(rst), .port_addr(addr), .wr8(wr8), .wr16(wr16),
    .rd8(rd8), .wdata(wdata), .ff_clear(clr), .prog_valid(pv),
    .prog_ch(pch), .prog_count(pcnt), .rdata(rdata_w));

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_ff[c] = 1'b0; m_exp[c] = 8'h00;
      for (int k = 0; k < 4; k++) begin
        m_cur[c][k] = '0; m_prog[c][k] = '0;
        m_base[c][k][0] = '0; m_base[c][k][1] = '0;
      end
    end
  endtask

  // One clock step with all inputs; model applied after the edge.
  task automatic step(input string tag, input logic [3:0] a, input logic w8,
                      input logic w16, input logic r8, input logic [15:0] d,
                      input logic cl, input logic p_v, input logic [1:0] p_c,
                      input logic [17:0] p_n);
    @(negedge clk);
    addr = a; wr8 = w8; wr16 = w16; rd8 = r8; wdata = d;
    clr = cl; pv = p_v; pch = p_c; pcnt = p_n;
    @(posedge clk);
    #1;
    for (int c = 0; c < 2; c++) begin
      logic hit, sel, re;
      logic [1:0] ch;
      logic [17:0] val;
      hit = (c == 0) ? 1'b1 : !a[0];
      ch  = (c == 0) ? a[2:1] : a[3:2];
      sel = (c == 0) ? a[0] : a[1];
      re  = 1'b0;
      if (r8 && hit) begin
        if (sel) val = (18'(m_base[c][ch][1]) << c) - m_prog[c][ch];
        else     val = m_cur[c][ch] + m_prog[c][ch];
        val = val >> (c + (m_ff[c] ? 8 : 0));
        m_exp[c] = val[7:0];
      end
      if (w8 && hit) begin
        if (m_ff[c]) begin
          m_base[c][ch][sel][15:8] = d[7:0]; re = 1'b1;
        end else begin
          m_base[c][ch][sel][7:0] = d[7:0];
        end
      end
      if (w16 && hit) begin
        m_base[c][ch][sel] = d; re = 1'b1;
      end
      if (p_v) m_prog[c][p_c] = p_n;
      if (re) begin
        m_cur[c][ch]  = 18'(m_base[c][ch][0]) << c;
        m_prog[c][ch] = '0;
      end
      if (cl) m_ff[c] = 1'b0;
      else if ((w8 || r8) && hit) m_ff[c] = ~m_ff[c];
    end
    if (r8) begin
      check8({tag, " byte"}, rdata_b, m_exp[0]);
      check8({tag, " word"}, rdata_w, m_exp[1]);
    end
    @(negedge clk);
    wr8 = 0; wr16 = 0; rd8 = 0; clr = 0; pv = 0;
  endtask

  task automatic wr_b(input string t, input logic [3:0] a, input logic [7:0] d);
    step(t, a, 1, 0, 0, {8'h00, d}, 0, 0, 2'd0, 18'd0);
  endtask
  task automatic rd_b(input string t, input logic [3:0] a);
    step(t, a, 0, 0, 1, 16'h0, 0, 0, 2'd0, 18'd0);
  endtask
  task automatic clear_ptr();
    step("clr", 4'd0, 0, 0, 0, 16'h0, 1, 0, 2'd0, 18'd0);
  endtask
  task automatic rd_pair(input string t, input logic [3:0] a);
    clear_ptr();
    rd_b(t, a);
    rd_b(t, a);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    addr = 0; wr8 = 0; wr16 = 0; rd8 = 0; wdata = 0;
    clr = 0; pv = 0; pch = 0; pcnt = 0;
    rst = 1;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R11: reset state
    check8("R11 rdata byte", rdata_b, 8'h00);
    check8("R11 rdata word", rdata_w, 8'h00);
    for (int a = 0; a < 16; a++) rd_pair("R11 readback", 4'(a));

    // R1 R2 R3 R6 R7 R8: byte-wise programming sweep over all ports
    for (int a = 0; a < 16; a++) begin
      clear_ptr();
      wr_b("R2", 4'(a), 8'(a * 17 + 3));
      rd_b("R2 live state after low write", 4'(a));
      clear_ptr();
      wr_b("R2", 4'(a), 8'(a * 17 + 5));
      wr_b("R3", 4'(a), 8'(a * 29 + 8'h41));
      for (int b = 0; b < 16; b++) rd_pair("R1 R7 R8 sweep", 4'(b));
    end

    // R10: progress for every channel, then read all registers
    for (int k = 0; k < 4; k++)
      step("R10", 4'd0, 0, 0, 0, 16'h0, 0, 1, 2'(k), 18'(k * 12345 + 777));
    for (int b = 0; b < 16; b++) rd_pair("R10 R7 R8 progress", 4'(b));
    step("R10 large", 4'd0, 0, 0, 0, 16'h0, 0, 1, 2'd2, 18'h3FFF0);
    for (int b = 0; b < 16; b++) rd_pair("R8 wrap", 4'(b));

    // R5: 16-bit write leaves the pointer; ptr at 1 before and after
    clear_ptr();
    rd_b("R5 pre", 4'd2);
    step("R5", 4'd4, 0, 1, 0, 16'hBEEF, 0, 0, 2'd0, 18'd0);
    step("R5", 4'd9, 0, 1, 0, 16'h1234, 0, 0, 2'd0, 18'd0);
    rd_b("R5 pointer kept", 4'd4);
    rd_b("R5 pointer kept", 4'd4);
    for (int b = 0; b < 16; b++) rd_pair("R5 R6 readback", 4'(b));

    // R9: clear with a simultaneous read uses old pointer, then pointer 0
    clear_ptr();
    rd_b("R9 setup", 4'd5);
    step("R9 read with clear", 4'd5, 0, 0, 1, 16'h0, 1, 0, 2'd0, 18'd0);
    rd_b("R9 after clear", 4'd5);
    step("R9 write with clear", 4'd6, 1, 0, 0, 16'h00A5, 1, 0, 2'd0, 18'd0);
    wr_b("R9 low after clear", 4'd6, 8'h3C);
    for (int b = 0; b < 16; b++) rd_pair("R9 readback", 4'(b));

    // R10: progress and reinitialisation on the same channel, same cycle
    step("R10 set", 4'd0, 0, 0, 0, 16'h0, 0, 1, 2'd1, 18'd999);
    step("R10 collide", 4'd2, 0, 1, 0, 16'h7777, 0, 1, 2'd1, 18'd555);
    for (int b = 0; b < 16; b++) rd_pair("R10 reinit wins", 4'(b));

    // R1: odd port on word controller ignored (rdata held, no pointer move)
    clear_ptr();
    rd_b("R1 setup", 4'd0);
    step("R1 odd write", 4'd3, 1, 0, 0, 16'h00FF, 0, 0, 2'd0, 18'd0);
    rd_b("R1 odd read", 4'd1);
    for (int b = 0; b < 16; b++) rd_pair("R1 readback", 4'(b));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule